// File: doc/BRIEF.md
# Level-1 Trigger Decoder with Pending-Trigger FIFO

This block watches a serial command line that is sampled once per bunch crossing on the module clock. When the line carries the trigger pattern, the block sends a single-crossing level-1 accept pulse to the front-end chips. Any bit that breaks the pattern returns the decoder to its idle state. Sequences that are not triggers are dropped without any further effect.

For every accept, the block stores one 16-bit tag in a small first-in first-out queue. The tag holds the running accept number in its upper byte and the crossing number in its lower byte. The event builder reads these tags later with a pop strobe.

If a trigger arrives while the queue is full, the pulse is still sent to the front-ends but no tag is stored. In that case a sticky error flag is raised.

Top module: `l1_trig_decoder`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves `l1Accept` low, `fifoEmpty` high, `fifoFull` low and `overflow` low. It also zeroes the accept counter and the crossing counter.
- R2: The trigger pattern is the 5-bit value 11101, sent most significant bit first, one bit per clock. `l1Accept` is high for exactly the one clock cycle after the edge that samples the final bit.
- R3: A bit that does not match the next expected pattern bit returns the decoder to idle. That bit is never reused as the start of a new pattern. So the streams 111101, 11100 and 1101 produce no accept and store nothing.
- R4: Each accept pushes one entry. Bits [15:8] hold the number of earlier accepts since reset, modulo 256. Bits [7:0] hold the number of clock edges since reset release, counted up to the edge that samples the final pattern bit, modulo 256.
- R5: Trigger commands sent back to back with no gap each give their own pulse, five cycles apart, and their own entry in order.
- R6: `popData` shows the oldest entry whenever `fifoEmpty` is low, and a `popReq` cycle removes it. A `popReq` on an empty queue has no effect.
- R7: After 16 unread entries, `fifoFull` is high. A trigger in that state still pulses `l1Accept`, stores nothing and still advances the accept counter. It also sets `overflow`, which stays high until reset.
- R8: A reset in the middle of a pattern clears the partial match, so the remaining bits alone cause no accept.
- R9: The accept number wraps from 255 to 0, and the crossing number also wraps modulo 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock, one edge per crossing |
| rst | input | 1 | Synchronous reset, active high |
| cmdIn | input | 1 | Serial command line |
| popReq | input | 1 | Remove the oldest stored tag |
| l1Accept | output | 1 | Level-1 accept pulse to the front-ends |
| popData | output | 16 | Oldest tag: accept number [15:8], crossing number [7:0] |
| fifoEmpty | output | 1 | No tag is stored |
| fifoFull | output | 1 | All 16 slots are in use |
| overflow | output | 1 | Sticky flag: a tag was lost while the queue was full |

## Verification
The hardest states to reach from the ports are the lost-tag path and the accept-number wrap. Reaching the queue boundary takes sixteen full serial commands with no reads. The wrap needs more than 256 accepts while the queue is kept drained. The stimulus fills the queue with back-to-back commands, adds one more, then drains it and checks that the next stored tag skips the lost number. A long loop of trigger-then-pop pairs carries both counters across their wrap points. Bit streams that only resemble the pattern, and a reset in the middle of a pattern, cover the rule that a mismatch sends the decoder back to idle.

// File: rtl/trgdec_pkg.sv
package trgdec_pkg;
  // strobes from the command decoder to the tag datapath
  typedef struct packed {
    logic trigHit;
  } ctrlStrb_t;
endpackage

// File: rtl/trgdec_ctrl.sv
module trgdec_ctrl
  import trgdec_pkg::*;
#(
  parameter int PAT_LEN = 5,
  parameter logic [PAT_LEN-1:0] PATTERN = 5'b11101
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      cmdIn,
  output ctrlStrb_t strb,
  output logic      l1Accept
);
  localparam int IDX_W = (PAT_LEN > 2) ? $clog2(PAT_LEN) : 1;

  // matchIdx = number of pattern bits already matched; values >= PAT_LEN are illegal
  logic [IDX_W-1:0] matchIdx;
  logic [IDX_W-1:0] matchNxt;
  logic             hit;
  logic             expBit;

  always_comb begin
    hit      = 1'b0;
    matchNxt = '0;
    expBit   = 1'b0;
    if (int'(matchIdx) < PAT_LEN) begin
      expBit = PATTERN[IDX_W'(PAT_LEN - 1) - matchIdx];
      if (cmdIn == expBit) begin
        if (int'(matchIdx) == PAT_LEN - 1) begin
          hit      = 1'b1;
          matchNxt = '0;
        end else begin
          matchNxt = matchIdx + IDX_W'(1);
        end
      end
      // mismatch: back to idle, the bit is not reused
    end
    // illegal index: back to idle
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      matchIdx <= '0;
      l1Accept <= 1'b0;
    end else begin
      matchIdx <= matchNxt;
      l1Accept <= hit;
    end
  end

  always_comb begin
    strb         = '0;
    strb.trigHit = hit;
  end
endmodule

// File: rtl/trgdec_dpath.sv
module trgdec_dpath
  import trgdec_pkg::*;
#(
  parameter int L1_W  = 8,
  parameter int BC_W  = 8,
  parameter int DEPTH = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  ctrlStrb_t            strb,
  input  logic                 popReq,
  output logic [L1_W+BC_W-1:0] popData,
  output logic                 fifoEmpty,
  output logic                 fifoFull,
  output logic                 overflow
);
  localparam int ENT_W = L1_W + BC_W;
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam bit POW2  = (DEPTH & (DEPTH - 1)) == 0;

  logic [L1_W-1:0]  l1Id;
  logic [BC_W-1:0]  bcId;
  logic [ENT_W-1:0] slot [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr, wrNxt, rdNxt;
  logic [CNT_W-1:0] count;
  logic             doPush, doPop;

  assign fifoEmpty = (count == '0);
  assign fifoFull  = (count == CNT_W'(DEPTH));
  assign doPush    = strb.trigHit && !fifoFull;
  assign doPop     = popReq && !fifoEmpty;
  assign popData   = slot[rdPtr];

  generate
    if (POW2) begin : gWrapNat
      assign wrNxt = wrPtr + PTR_W'(1);
      assign rdNxt = rdPtr + PTR_W'(1);
    end else begin : gWrapCmp
      assign wrNxt = (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + PTR_W'(1);
      assign rdNxt = (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + PTR_W'(1);
    end
  endgenerate

  // counters tagging each accept
  always_ff @(posedge clk) begin
    if (rst) begin
      l1Id <= '0;
      bcId <= '0;
    end else begin
      bcId <= bcId + BC_W'(1);
      if (strb.trigHit) l1Id <= l1Id + L1_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < DEPTH; s++) slot[s] <= '0;
    end else if (doPush) begin
      for (int s = 0; s < DEPTH; s++)
        if (wrPtr == PTR_W'(s)) slot[s] <= {l1Id, bcId};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (doPush) wrPtr <= wrNxt;
      if (doPop)  rdPtr <= rdNxt;
      case ({doPush, doPop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
      if (strb.trigHit && fifoFull) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/l1_trig_decoder.sv
module l1_trig_decoder
  import trgdec_pkg::*;
#(
  parameter int L1_W    = 8,
  parameter int BC_W    = 8,
  parameter int DEPTH   = 16,
  parameter int PAT_LEN = 5,
  parameter logic [PAT_LEN-1:0] PATTERN = 5'b11101
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmdIn,
  input  logic                 popReq,
  output logic                 l1Accept,
  output logic [L1_W+BC_W-1:0] popData,
  output logic                 fifoEmpty,
  output logic                 fifoFull,
  output logic                 overflow
);
  ctrlStrb_t strb;

  trgdec_ctrl #(.PAT_LEN(PAT_LEN), .PATTERN(PATTERN)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cmdIn    (cmdIn),
    .strb     (strb),
    .l1Accept (l1Accept)
  );

  trgdec_dpath #(.L1_W(L1_W), .BC_W(BC_W), .DEPTH(DEPTH)) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .popReq    (popReq),
    .popData   (popData),
    .fifoEmpty (fifoEmpty),
    .fifoFull  (fifoFull),
    .overflow  (overflow)
  );
endmodule

// File: rtl/trgdec_checker.sv
module trgdec_checker (
  input logic clk,
  input logic rst,
  input logic popReq,
  input logic l1Accept,
  input logic fifoEmpty,
  input logic fifoFull,
  input logic overflow
);
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    l1Accept |=> !l1Accept); // R2

  AST_ACCEPT_STORED: assert property (@(posedge clk) disable iff (rst)
    l1Accept |-> !fifoEmpty); // R4

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(fifoEmpty && fifoFull)); // R6

  AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    fifoEmpty |=> (fifoEmpty || l1Accept)); // R6

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (fifoFull && !popReq) |=> fifoFull); // R7

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow); // R7

  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> l1Accept); // R7
endmodule

bind l1_trig_decoder trgdec_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .popReq    (popReq),
  .l1Accept  (l1Accept),
  .fifoEmpty (fifoEmpty),
  .fifoFull  (fifoFull),
  .overflow  (overflow)
);

// File: tb/sim_l1_trig_decoder.sv
`timescale 1ns/1ps
module sim_l1_trig_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmdIn = 1'b0;
  logic        popReq = 1'b0;
  logic        l1Accept;
  logic [15:0] popData;
  logic        fifoEmpty, fifoFull, overflow;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int dueCyc = -1;
  int accSeen = 0;
  int l1Model = 0;
  logic [15:0] q[$];

  always #2 clk = ~clk;

  l1_trig_decoder u0 (
    .clk(clk), .rst(rst), .cmdIn(cmdIn), .popReq(popReq),
    .l1Accept(l1Accept), .popData(popData),
    .fifoEmpty(fifoEmpty), .fifoFull(fifoFull), .overflow(overflow)
  );

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // pulse monitor: accept must appear exactly in the due cycle (R2)
  always @(negedge clk) begin
    if (!rst) begin
      if (l1Accept) accSeen++;
      chk(l1Accept == (cyc == dueCyc), "R2 pulse timing", int'(l1Accept), int'(cyc == dueCyc));
    end
  end

  task automatic driveBit(input logic b);
    @(negedge clk);
    cmdIn = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) driveBit(1'b0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; cmdIn = 1'b0; popReq = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    dueCyc = -1; l1Model = 0; q.delete();
  endtask

  task automatic sendTrig();
    logic [4:0] pat = 5'b11101;
    for (int i = 4; i >= 0; i--) begin
      driveBit(pat[i]);
      if (i == 0) begin
        dueCyc = cyc + 1;
        if (q.size() < 16) q.push_back({8'(l1Model), 8'(cyc)});
        l1Model++;
      end
    end
  endtask

  task automatic sendBits(input logic [7:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) driveBit(bits[i]);
  endtask

  task automatic popCheck(input string req);
    logic [15:0] e;
    @(negedge clk);
    chk(!fifoEmpty, req, int'(fifoEmpty), 0);
    e = (q.size() > 0) ? q[0] : 16'h0;
    chk(popData == e, req, int'(popData), int'(e));
    popReq = 1'b1;
    @(negedge clk);
    popReq = 1'b0;
    if (q.size() > 0) void'(q.pop_front());
  endtask

  task automatic t_reset();
    doReset();
    @(negedge clk);
    chk(l1Accept == 1'b0, "R1 accept low", int'(l1Accept), 0);
    chk(fifoEmpty == 1'b1, "R1 empty", int'(fifoEmpty), 1);
    chk(fifoFull == 1'b0, "R1 not full", int'(fifoFull), 0);
    chk(overflow == 1'b0, "R1 no overflow", int'(overflow), 0);
  endtask

  task automatic t_single();
    int a0;
    doReset();
    idle(3);
    a0 = accSeen;
    sendTrig();
    idle(3);
    chk(accSeen == a0 + 1, "R2 one pulse", accSeen - a0, 1);
    popCheck("R4 tag of first accept");
    chk(fifoEmpty, "R6 empty after pop", int'(fifoEmpty), 1);
  endtask

  task automatic t_noOverlap();
    int a0;
    a0 = accSeen;
    sendBits(8'b00111101, 6); idle(3);
    sendBits(8'b00011100, 5); idle(3);
    sendBits(8'b00001101, 4); idle(3);
    chk(accSeen == a0, "R3 no accept on near patterns", accSeen - a0, 0);
    chk(fifoEmpty, "R3 nothing stored", int'(fifoEmpty), 1);
  endtask

  task automatic t_backToBack();
    int a0;
    a0 = accSeen;
    sendTrig(); sendTrig(); sendTrig();
    idle(3);
    chk(accSeen == a0 + 3, "R5 three pulses", accSeen - a0, 3);
    for (int i = 0; i < 3; i++) popCheck("R5 ordered tags");
  endtask

  task automatic t_popEmpty();
    doReset();
    idle(2);
    @(negedge clk); popReq = 1'b1;
    @(negedge clk); popReq = 1'b0;
    chk(fifoEmpty && !fifoFull, "R6 pop on empty ignored", int'({fifoEmpty, fifoFull}), 2);
    sendTrig(); idle(2);
    popCheck("R6 data after empty pop");
  endtask

  task automatic t_overflow();
    int a0;
    doReset();
    a0 = accSeen;
    for (int i = 0; i < 16; i++) sendTrig();
    idle(2);
    chk(fifoFull, "R7 full after 16", int'(fifoFull), 1);
    chk(!overflow, "R7 no overflow yet", int'(overflow), 0);
    sendTrig(); idle(2);
    chk(accSeen == a0 + 17, "R7 pulse while full", accSeen - a0, 17);
    chk(overflow, "R7 overflow set", int'(overflow), 1);
    for (int i = 0; i < 16; i++) popCheck("R7 stored tags");
    chk(fifoEmpty, "R7 drained", int'(fifoEmpty), 1);
    chk(overflow, "R7 overflow sticky", int'(overflow), 1);
    sendTrig(); idle(2);
    popCheck("R7 accept number skips lost tag");
    doReset();
    @(negedge clk);
    chk(!overflow, "R7 overflow cleared by reset", int'(overflow), 0);
  endtask

  task automatic t_resetMid();
    int a0;
    doReset();
    a0 = accSeen;
    sendBits(8'b00001110, 4);
    doReset();
    driveBit(1'b1);
    idle(4);
    chk(accSeen == a0, "R8 partial pattern discarded", accSeen - a0, 0);
    chk(fifoEmpty, "R8 nothing stored", int'(fifoEmpty), 1);
  endtask

  task automatic t_wrap();
    doReset();
    for (int i = 0; i < 260; i++) begin
      sendTrig();
      idle(1);
      popCheck("R9 counters wrap");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_noOverlap();
    t_backToBack();
    t_popEmpty();
    t_overflow();
    t_resetMid();
    t_wrap();
    idle(3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule